// File: doc/BRIEF.md
# Serial BCH Syndrome Engine (length 31, three-error code)

This block takes a received word of the length-31, three-error-correcting binary BCH code one bit per clock and computes the six syndrome values the next stages of a decoder need. The code has sixteen data bits and fifteen check bits. Its field arithmetic runs over GF(32), built on the primitive polynomial x^5 + x^2 + 1. Each syndrome is the received polynomial evaluated at a power of the primitive element alpha. A shared counter frames each word, and six small constant-multiplier cells keep the running values.

The host pulses `start_i` to open a word. It then presents 31 bits on `bit_i`, qualified by `valid_i`, with the highest-degree coefficient first. One cycle after the last accepted bit, `done_o` pulses. The six syndromes then sit on `syn_o` together with an all-zero flag. The flag indicates that no error was detected. The values hold until the next start pulse or reset. Key-equation solving, root search and bit correction belong to later blocks.

Top module: `bch_syndrome`

## Requirements
- R1: After a word, lane j of `syn_o` (bits [5j-1:5j-5], j = 1..6) holds S_j = r(alpha^j) in 5-bit tuple form. Tuple bit k is the coefficient of alpha^k, and alpha^5 = alpha^2 + 1.
- R2: The first accepted bit of a word is the coefficient of x^30 and the 31st is the coefficient of x^0.
- R3: A cycle with `valid_i` low during a word neither advances the bit count nor changes any syndrome.
- R4: `done_o` is high for exactly one cycle, the cycle after the 31st accepted bit, and is low at every other time.
- R5: `zero_o` is high exactly when all six lanes of `syn_o` are zero, so at `done_o` it reports an error-free word.
- R6: A `start_i` pulse clears every syndrome to zero and begins a new word, including in the middle of a word. A bit presented in the start cycle is not accepted.
- R7: Bits presented while no word is open (after reset before any start, or after `done_o`) are ignored and the syndromes hold their values.
- R8: On `done_o`, S2 = S1^2, S4 = S2^2 and S6 = S3^2 in the field.
- R9: `rst_n` low at a clock edge clears all syndromes, closes any open word and drops `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a new word and clears the syndromes |
| valid_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Received bit, highest degree first |
| syn_o | output | 30 | Six 5-bit syndromes, S1 in the low lane |
| done_o | output | 1 | One-cycle pulse after the 31st bit |
| zero_o | output | 1 | All syndromes are zero |

## Verification
A wrong bit count shows up at the ports straight away. A counter that is off by one moves `done_o` a cycle early or late on the very first word. A syndrome cell that starts from a stale value, or that multiplies by the wrong constant, shows up as soon as `done_o` is sampled. Its lane then differs from the independently evaluated polynomial, and usually also breaks the squaring relation between lanes. A frame that fails to close shows up within a few cycles, because bits presented after `done_o` then change `syn_o` when they should not.

// File: rtl/bch_syn_pkg.sv
// Package: field and code constants plus GF(2^M) helper functions.
// Assumes tuple bit k is the coefficient of alpha^k.
package bch_syn_pkg;
    parameter int GF_M = 5;
    parameter logic [GF_M-1:0] GF_POLY = 5'b00101;  // low terms of x^5+x^2+1
    parameter int T_CORR = 3;
    localparam int CW_LEN = (1 << GF_M) - 1;
    localparam int N_SYN  = 2 * T_CORR;
    localparam int CNT_W  = $clog2(CW_LEN);

    typedef logic [GF_M-1:0] gf_t;

    // Multiply by alpha once: shift up, fold the overflow term back.
    function automatic gf_t gf_times_alpha(input gf_t x);
        gf_t r;
        r = {x[GF_M-2:0], 1'b0};
        if (x[GF_M-1]) r = r ^ GF_POLY;
        return r;
    endfunction

    // Multiply by alpha^k with k a constant; unrolls to an XOR network.
    function automatic gf_t gf_times_apow(input gf_t x, input int k);
        gf_t r;
        r = x;
        for (int i = 0; i < k; i++) r = gf_times_alpha(r);
        return r;
    endfunction

    // General field product, shift-and-add from the top bit of b.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t r;
        r = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            r = gf_times_alpha(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction
endpackage

// File: rtl/bch_frame_ctl.sv
// Module: word framing. Counts accepted bits, opens on start, closes
// after CW_LEN bits and emits a one-cycle done pulse.
// Assumes start has priority over a bit presented in the same cycle.
module bch_frame_ctl
    import bch_syn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    output logic take_o,
    output logic open_o,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    assign last_bit = (cnt_q == CNT_W'(CW_LEN - 1));
    assign take_o   = open_o && valid_i && !start_i;

    // Frame state: open flag, bit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            open_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                open_o <= 1'b1;
                cnt_q  <= '0;
            end else if (take_o) begin
                if (last_bit) begin
                    open_o <= 1'b0;
                    done_o <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CW_LEN - 1)); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && last_bit) |=> done_o); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !valid_i && !start_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/bch_syn_cell.sv
// Module: one syndrome accumulator, S <= S * alpha^POWER + bit (Horner).
// Assumes bits arrive highest degree first; clear wins over shift.
module bch_syn_cell
    import bch_syn_pkg::*;
#(
    parameter int POWER = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic shift_i,
    input  logic bit_i,
    output gf_t  syn_o
);
    localparam int STEP = POWER % CW_LEN;

    gf_t syn_next;

    // Next value: scale by the constant and add the bit as element 1.
    always_comb begin
        syn_next = gf_times_apow(syn_o, STEP);
        syn_next[0] = syn_next[0] ^ bit_i;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)       syn_o <= '0;
        else if (clear_i) syn_o <= '0;
        else if (shift_i) syn_o <= syn_next;
    end

    AST_CELL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (syn_o == '0)); // R6
    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i) |=> $stable(syn_o)); // R3
endmodule

// File: rtl/bch_syndrome.sv
// Module: top of the serial syndrome engine. One framing controller
// drives N_SYN accumulator cells; lane j-1 holds S_j.
// Assumes start_i is a single-cycle pulse in the caller's clock domain.
module bch_syndrome
    import bch_syn_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    valid_i,
    input  logic                    bit_i,
    output logic [N_SYN*GF_M-1:0]   syn_o,
    output logic                    done_o,
    output logic                    zero_o
);
    logic take;
    logic open_w;

    bch_frame_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (valid_i),
        .take_o  (take),
        .open_o  (open_w),
        .done_o  (done_o)
    );

    for (genvar gj = 1; gj <= N_SYN; gj++) begin : g_cell
        bch_syn_cell #(.POWER(gj)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_i),
            .shift_i (take),
            .bit_i   (bit_i),
            .syn_o   (syn_o[gj*GF_M-1 -: GF_M])
        );
    end

    // Error-free indication across all lanes.
    always_comb zero_o = (syn_o == '0);

    for (genvar gk = 1; gk <= T_CORR; gk++) begin : g_sq
        AST_EVEN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (syn_o[2*gk*GF_M-1 -: GF_M] ==
                        gf_mul(syn_o[gk*GF_M-1 -: GF_M], syn_o[gk*GF_M-1 -: GF_M]))); // R8
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (syn_o == '0) && !done_o); // R6
    AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_w && !start_i) |=> $stable(syn_o)); // R7
endmodule

// File: tb/sim_bch_syndrome.sv
module sim_bch_syndrome;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [29:0] syn_o;
    logic        done_o;
    logic        zero_o;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    bch_syndrome u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .bit_i(bit_i), .syn_o(syn_o), .done_o(done_o), .zero_o(zero_o)
    );

    // Bench-side field tables: power to tuple and tuple to power.
    logic [4:0] ex [0:30];
    int         lg [0:31];

    localparam int NV = 8;
    localparam logic [30:0] VECS [0:NV-1] = '{
        31'h00000000, 31'h7FFFFFFF, 31'h40000000, 31'h00000001,
        31'h7FFF7BFE, 31'h12345678, 31'h5A5A5A5A, 31'h00010000 };
    localparam logic [NV-1:0] GAPS = 8'b1010_0110;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] bmul(input logic [4:0] a, input logic [4:0] b);
        if (a == 0 || b == 0) return 5'd0;
        return ex[(lg[a] + lg[b]) % 31];
    endfunction

    // Polynomial evaluation at alpha^j, term by term.
    function automatic logic [4:0] exp_syn(input logic [30:0] v, input int j);
        logic [4:0] acc = 5'd0;
        for (int i = 0; i < 31; i++) if (v[i]) acc ^= ex[(i * j) % 31];
        return acc;
    endfunction

    function automatic logic [4:0] lane(input int j);
        return syn_o[5*j-1 -: 5];
    endfunction

    task automatic run_block(input logic [30:0] v, input bit gaps);
        @(negedge clk); start_i = 1; valid_i = 1; bit_i = 1;  // R6: bit ignored
        @(negedge clk); start_i = 0;
        for (int i = 30; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin  // R3 idle cycles with junk data
                valid_i = 0; bit_i = ~v[i]; @(negedge clk);
            end
            valid_i = 1; bit_i = v[i]; @(negedge clk);
            if (i == 1) chk(done_o == 0, "R4 early done", done_o, 0);
        end
        valid_i = 0;
    endtask

    task automatic check_result(input logic [30:0] v);
        bit allz = 1;
        chk(done_o == 1, "R4 done pulse", done_o, 1);
        for (int j = 1; j <= 6; j++) begin
            chk(lane(j) == exp_syn(v, j), "R1 R2 syndrome", lane(j), exp_syn(v, j));
            if (exp_syn(v, j) != 0) allz = 0;
        end
        chk(zero_o == allz, "R5 zero flag", zero_o, allz);
        for (int k = 1; k <= 3; k++)
            chk(lane(2*k) == bmul(lane(k), lane(k)), "R8 square", lane(2*k), bmul(lane(k), lane(k)));
        @(negedge clk);
        chk(done_o == 0, "R4 done width", done_o, 0);
    endtask

    initial begin
        ex[0] = 5'd1;
        for (int i = 1; i < 31; i++)
            ex[i] = ex[i-1][4] ? ({ex[i-1][3:0], 1'b0} ^ 5'b00101) : {ex[i-1][3:0], 1'b0};
        lg[0] = 0;
        for (int i = 0; i < 31; i++) lg[ex[i]] = i;

        repeat (3) @(negedge clk);
        chk(syn_o == 0 && done_o == 0 && zero_o == 1, "R9 reset state", {syn_o[1:0], done_o, zero_o}, 1);
        rst_n = 1;
        // R7: bits before any start are ignored
        valid_i = 1; bit_i = 1;
        repeat (6) @(negedge clk);
        valid_i = 0;
        chk(syn_o == 0 && done_o == 0, "R7 unframed bits", syn_o, 0);

        for (int n = 0; n < NV; n++) begin
            run_block(VECS[n], GAPS[n]);
            check_result(VECS[n]);
        end

        // R7: bits after done leave the result in place
        run_block(31'h12345678, 0);
        check_result(31'h12345678);
        valid_i = 1; bit_i = 1;
        repeat (5) @(negedge clk);
        valid_i = 0;
        chk(lane(1) == exp_syn(31'h12345678, 1) && lane(6) == exp_syn(31'h12345678, 6),
            "R7 after done", lane(1), exp_syn(31'h12345678, 1));
        chk(done_o == 0, "R7 no extra done", done_o, 0);

        // R6: restart in the middle of a word
        @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
        valid_i = 1; bit_i = 1; repeat (12) @(negedge clk);
        run_block(31'h0F0F0F0F, 0);
        check_result(31'h0F0F0F0F);

        // R9: reset mid-word clears and closes the frame
        @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
        valid_i = 1; bit_i = 1; repeat (7) @(negedge clk);
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk(syn_o == 0 && done_o == 0, "R9 mid-word reset", syn_o, 0);
        repeat (30) @(negedge clk);
        valid_i = 0;
        chk(syn_o == 0 && done_o == 0, "R9 frame closed", syn_o, 0);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule